// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block is a supervisor core for a processor subsystem. It watches a software-toggled watchdog input for activity and raises an active-low fault when that input stays quiet for too long. It also produces a timed active-low system reset whose causes are a manual-reset request and a supply-good level. The supply-good level arrives already synchronised. All timing is counted in pulses of a slow `tick` enable, so the block runs from any fast clock.

A build option loops the watchdog fault back into the manual-reset path. With that option set, a watchdog input stuck at either level turns into a periodic reset pulse train. Each pulse is one reset period long, and the pulses repeat roughly every watchdog period plus one reset period. The default counts keep an 8:1 ratio between the watchdog period and the reset period.

Top module: `sup_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rst_out_n` is 0 and `wd_fault_n` is 1.
- R2: When `supply_ok` is driven high in cycle D, with `mr_n` high and `tick` high every cycle, `rst_out_n` is still 0 in cycle D+RST_TICKS-1 and is 1 in cycle D+RST_TICKS.
- R3: `supply_ok` low makes `rst_out_n` 0 and `wd_fault_n` 1 one cycle later. Both stay that way for as long as `supply_ok` is low, however long `wd_in` is quiet.
- R4: `mr_n` passes through a two-stage synchroniser. `mr_n` driven low in cycle D gives `rst_out_n` = 0 from cycle D+3. `mr_n` driven high again in cycle E releases reset in cycle E+2+RST_TICKS.
- R5: A new reset cause that arrives while the reset count is running restarts the count from zero. Release then follows the rule of R4, taken from the last time `mr_n` goes high.
- R6: After reset releases in cycle Rl, the watchdog counts from zero. If `wd_in` does not change, `wd_fault_n` is 1 in cycle Rl+WD_TICKS-1 and 0 in cycle Rl+WD_TICKS.
- R7: Any change of `wd_in`, rising or falling, in cycle D restarts the watchdog count. A fault that is already present then clears: `wd_fault_n` is 0 in D+2 and 1 in D+3. With no further change, `wd_fault_n` falls in cycle D+3+WD_TICKS.
- R8: When `rst_out_n` goes low, `wd_fault_n` is 1 on the following cycle and the watchdog count is zero.
- R9: With FEEDBACK_EN=1 and `wd_in` stuck, a fault in cycle F drives `rst_out_n` low from F+1 through F+1+RST_TICKS. The fault clears in F+2, and the next fault comes WD_TICKS cycles after the release.
- R10: With FEEDBACK_EN=0, a watchdog fault has no effect on `rst_out_n`.
- R11: Both counters advance only in cycles where `tick` is 1. With `tick` low, a reset whose causes have gone away stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow time-base enable; counters step on cycles where it is 1 |
| wd_in | input | 1 | Asynchronous watchdog kick input; any edge counts as activity |
| mr_n | input | 1 | Asynchronous active-low manual-reset request |
| supply_ok | input | 1 | Synchronous supply-good level, high when the supply is in range |
| wd_fault_n | output | 1 | Registered active-low watchdog fault |
| rst_out_n | output | 1 | Registered active-low system reset |

## Verification
A reset counter that is off by one shows up as `rst_out_n` releasing one cycle early or late, so every release is sampled in both the last held cycle and the first free cycle. A watchdog counter that keeps a stale value is caught the same way. If it is not cleared by reset or by an input edge, the fault edge lands at the wrong cycle within one watchdog period of the release or the edge. A broken synchroniser or edge detector shifts the reset assertion or the fault recovery by at least one cycle, and that shift is visible at once. A broken feedback path shows up within one watchdog period as a missing pulse train, or as resets that should not happen.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Width of a counter that runs from 0 to n-1.
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int                WIDTH  = 1,
  parameter int                STAGES = 2,
  parameter logic [WIDTH-1:0]  INIT   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= INIT;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sup_rstgen.sv
module sup_rstgen #(
  parameter int RST_TICKS = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cause,
  output logic rst_n_o
);

  localparam int CW = sup_pkg::cnt_w(RST_TICKS);
  localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

  logic [CW-1:0] cnt;

  // Any cause restarts the pulse; release only after a full quiet count.
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_o <= 1'b0;
      cnt     <= '0;
    end else if (cause) begin
      rst_n_o <= 1'b0;
      cnt     <= '0;
    end else if (!rst_n_o && tick) begin
      if (cnt == LAST) begin
        rst_n_o <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int WD_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic wd_s,
  input  logic hold,
  output logic fault_n,
  output logic evt_o
);

  localparam int CW = sup_pkg::cnt_w(WD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

  logic          prev;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= wd_s;
  end

  assign evt_o = wd_s ^ prev;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      fault_n <= 1'b1;
      cnt     <= '0;
    end else if (evt_o) begin
      fault_n <= 1'b1;
      cnt     <= '0;
    end else if (tick && fault_n) begin
      if (cnt == LAST) begin
        fault_n <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sup_core.sv
module sup_core #(
  parameter int RST_TICKS   = 25,
  parameter int WD_TICKS    = 200,
  parameter int SYNC_STAGES = 2,
  parameter bit FEEDBACK_EN = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic wd_in,
  input  logic mr_n,
  input  logic supply_ok,
  output logic wd_fault_n,
  output logic rst_out_n
);

  logic mr_s;
  logic wd_s;
  logic mr_eff;
  logic rst_cause;
  logic wd_hold;
  logic wd_evt;

  sup_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES),
    .INIT  (2'b10)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({mr_n, wd_in}),
    .q  ({mr_s, wd_s})
  );

  generate
    if (FEEDBACK_EN) begin : g_fb
      assign mr_eff = mr_s & wd_fault_n;
    end else begin : g_nofb
      assign mr_eff = mr_s;
    end
  endgenerate

  assign rst_cause = ~mr_eff | ~supply_ok;
  assign wd_hold   = ~rst_out_n | ~supply_ok;

  sup_rstgen #(
    .RST_TICKS(RST_TICKS)
  ) u_rstgen (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .cause  (rst_cause),
    .rst_n_o(rst_out_n)
  );

  sup_wdog #(
    .WD_TICKS(WD_TICKS)
  ) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wd_s   (wd_s),
    .hold   (wd_hold),
    .fault_n(wd_fault_n),
    .evt_o  (wd_evt)
  );

endmodule

// File: rtl/sup_core_chk.sv
module sup_core_chk (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic rst_cause,
  input logic wd_evt,
  input logic rst_out_n,
  input logic wd_fault_n
);

  AST_SUPPLY_RESET: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !rst_out_n); // R3

  AST_SUPPLY_WD_OFF: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> wd_fault_n); // R3

  AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rst_cause |=> !rst_out_n); // R5

  AST_RESET_CLEARS_WD: assert property (@(posedge clk) disable iff (rst)
    !rst_out_n |=> wd_fault_n); // R8

  AST_NO_FAULT_ON_KICK: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_fault_n) |-> !$past(wd_evt)); // R7

  AST_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out_n) |-> !$past(rst_cause)); // R4

endmodule

bind sup_core sup_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .supply_ok (supply_ok),
  .rst_cause (rst_cause),
  .wd_evt    (wd_evt),
  .rst_out_n (rst_out_n),
  .wd_fault_n(wd_fault_n)
);

// File: tb/test_sup_core.sv
module test_sup_core;

  localparam int RT = 5;
  localparam int WT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic wd_in = 1'b0;
  logic mr_n = 1'b1;
  logic supply_ok = 1'b0;
  logic fault0, rstn0, fault1, rstn1;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    int    inst;
    int    sig;   // 0: rst_out_n, 1: wd_fault_n
    bit    val;
    string req;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  sup_core #(.RST_TICKS(RT), .WD_TICKS(WT), .FEEDBACK_EN(1'b0)) i_sup_core (
    .clk(clk), .rst(rst), .tick(tick), .wd_in(wd_in), .mr_n(mr_n),
    .supply_ok(supply_ok), .wd_fault_n(fault0), .rst_out_n(rstn0)
  );

  sup_core #(.RST_TICKS(RT), .WD_TICKS(WT), .FEEDBACK_EN(1'b1)) i_sup_core_fb (
    .clk(clk), .rst(rst), .tick(tick), .wd_in(wd_in), .mr_n(mr_n),
    .supply_ok(supply_ok), .wd_fault_n(fault1), .rst_out_n(rstn1)
  );

  function automatic bit pick(input int inst, input int sig);
    if (inst == 0) return (sig == 0) ? rstn0 : fault0;
    return (sig == 0) ? rstn1 : fault1;
  endfunction

  task automatic expect_at(input int c, input int inst, input int sig, input bit val,
                           input string req);
    exp_t e;
    e.cyc = c; e.inst = inst; e.sig = sig; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: compare expected items as their cycle comes up.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc <= cyc) begin
        bit act;
        act = pick(sb[i].inst, sb[i].sig);
        checks++;
        if (sb[i].cyc != cyc || act !== sb[i].val) begin
          errors++;
          $display("FAIL %s inst%0d %s cyc %0d: actual %0b expected %0b",
                   sb[i].req, sb[i].inst, (sb[i].sig == 0) ? "rst_out_n" : "wd_fault_n",
                   cyc, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  // Watchdog for the run itself
  initial begin
    wait (cyc >= 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cyc %0d expected < 20000", cyc);
      report();
    end
  end

  initial begin
    int d, e, rl, r2, t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state just after reset falls
    for (int k = 0; k < 2; k++) begin
      expect_at(cyc + 1, k, 0, 1'b0, "R1");
      expect_at(cyc + 1, k, 1, 1'b1, "R1");
    end
    repeat (4) @(negedge clk);

    // R2: power-up reset length
    d = cyc; supply_ok = 1'b1; rl = d + RT;
    for (int k = 0; k < 2; k++) begin
      expect_at(rl - 1, k, 0, 1'b0, "R2");
      expect_at(rl,     k, 0, 1'b1, "R2");
    end
    // R6: quiet watchdog input times out, no feedback instance
    expect_at(rl + WT - 1, 0, 1, 1'b1, "R6");
    expect_at(rl + WT,     0, 1, 1'b0, "R6");
    // R9: feedback pulse train
    expect_at(rl + WT,          1, 0, 1'b1, "R9");
    expect_at(rl + WT + 1,      1, 0, 1'b0, "R9");
    expect_at(rl + WT + 1,      1, 1, 1'b0, "R9");
    expect_at(rl + WT + 2,      1, 1, 1'b1, "R8");
    expect_at(rl + WT + 1 + RT, 1, 0, 1'b0, "R9");
    r2 = rl + WT + 2 + RT;
    expect_at(r2,          1, 0, 1'b1, "R9");
    expect_at(r2 + WT - 1, 1, 1, 1'b1, "R9");
    expect_at(r2 + WT,     1, 1, 1'b0, "R9");
    expect_at(r2 + WT + 1, 1, 0, 1'b0, "R9");
    // R10: no feedback, fault does not reset
    expect_at(r2 + WT + 1, 0, 0, 1'b1, "R10");
    expect_at(r2 + WT + 1, 0, 1, 1'b0, "R10");
    wait_to(r2 + WT + 3);

    // R7: an edge clears an existing fault, then periodic kicks
    d = cyc; wd_in = 1'b1;
    expect_at(d + 2, 0, 1, 1'b0, "R7");
    expect_at(d + 3, 0, 1, 1'b1, "R7");
    t = d;
    for (int k = 0; k < 6; k++) begin
      t = cyc + 20;
      wait_to(t);
      wd_in = ~wd_in;
      expect_at(t + 19, 0, 1, 1'b1, "R7");
    end
    expect_at(t + 2 + WT, 0, 1, 1'b1, "R7");
    expect_at(t + 3 + WT, 0, 1, 1'b0, "R7");
    wait_to(t + WT + 6);

    // R4 / R8: manual reset
    d = cyc; mr_n = 1'b0;
    expect_at(d + 2, 0, 0, 1'b1, "R4");
    expect_at(d + 3, 0, 0, 1'b0, "R4");
    expect_at(d + 3, 0, 1, 1'b0, "R8");
    expect_at(d + 4, 0, 1, 1'b1, "R8");
    repeat (10) @(negedge clk);
    e = cyc; mr_n = 1'b1;
    wait_to(e + 3);
    mr_n = 1'b0;            // R5: new cause during the count
    @(negedge clk);
    mr_n = 1'b1;
    expect_at(e + 2 + RT, 0, 0, 1'b0, "R5");
    expect_at(e + 5 + RT, 0, 0, 1'b0, "R5");
    rl = e + 6 + RT;
    expect_at(rl, 0, 0, 1'b1, "R5");
    expect_at(rl + WT - 1, 0, 1, 1'b1, "R6");
    expect_at(rl + WT,     0, 1, 1'b0, "R6");
    wait_to(rl + WT + 2);

    // R3: supply drop
    d = cyc; supply_ok = 1'b0;
    expect_at(d + 1, 0, 0, 1'b0, "R3");
    expect_at(d + 1, 0, 1, 1'b1, "R3");
    expect_at(d + WT + 10, 0, 1, 1'b1, "R3");
    expect_at(d + WT + 10, 0, 0, 1'b0, "R3");
    wait_to(d + WT + 12);

    // R11: tick gating holds the reset
    d = cyc; tick = 1'b0; supply_ok = 1'b1;
    expect_at(d + RT + 10, 0, 0, 1'b0, "R11");
    wait_to(d + RT + 12);
    d = cyc; tick = 1'b1;
    expect_at(d + RT - 1, 0, 0, 1'b0, "R11");
    expect_at(d + RT,     0, 0, 1'b1, "R11");
    expect_at(d + RT + WT, 0, 1, 1'b0, "R11");
    wait_to(d + RT + WT + 3);

    foreach (sb[i]) begin
      errors++;
      $display("FAIL %s: check at cyc %0d never evaluated, actual none expected %0b",
               sb[i].req, sb[i].cyc, sb[i].val);
    end
    done = 1'b1;
    report();
  end

endmodule